// File: doc/BRIEF.md
# Codec Link Interrupt Status Register

This block gathers the interrupt sources of an audio/modem codec link controller into one 8-bit status register and one combined interrupt line. Three groups of per-channel interrupt requests feed it: PCM capture channels, modem transmit channels and modem receive channels. Each group is reduced to a single summary bit. A summary bit is set while any request in its group is high and falls again once every request in the group has gone low. Software cannot write these bits.

The fourth status source comes from the link itself. Each received frame carries a slot-12 word, and a 1 in its lowest bit means that a codec general-purpose input has changed. That event sets a sticky change flag. The flag stays set until software writes a 1 to its position. If a new event arrives in the same cycle as the clear, the event wins, so no input change is lost. The combined interrupt output is high whenever any status bit that is in use is set.

The register is always readable on a parallel read bus and is written through a single write strobe. Bits 7:6 and 4:3 carry no function.

Top module: `codec_irq_status`

## Requirements
- R1: When `rst` is sampled high at a clock edge, the register is 0 after that edge and `irq_out` is 0. This holds even while requests are asserted.
- R2: Bit 5 of `reg_rd_data` equals the OR of `pcm_in_req` sampled at the previous rising clock edge.
- R3: Bit 2 of `reg_rd_data` equals the OR of `mdm_out_req` sampled at the previous rising clock edge.
- R4: Bit 1 of `reg_rd_data` equals the OR of `mdm_in_req` sampled at the previous rising clock edge.
- R5: Bits 7, 6, 4 and 3 of `reg_rd_data` always read 0, and writing 1s to them does not change them.
- R6: Bit 0 of `reg_rd_data` becomes 1 after an edge at which `frame_valid` is 1 and bit 0 of `slot12_data` is 1. When `frame_valid` is 0, or when bit 0 of `slot12_data` is 0 (whatever the other slot bits are), bit 0 is not set.
- R7: Once set, bit 0 stays 1 across edges that have no write carrying 1 in bit 0. This includes writes with bit 0 equal to 0.
- R8: An edge with `reg_wr_en` at 1 and bit 0 of `reg_wr_data` at 1 clears bit 0, unless a set event occurs at the same edge.
- R9: When a set event and a write-one-to-clear occur at the same edge, bit 0 is 1 after that edge.
- R10: Writes to bits 5, 2 and 1 have no effect. Those bits keep following their request inputs.
- R11: `irq_out` equals the OR of bits 5, 2, 1 and 0 of `reg_rd_data`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the status register |
| reg_wr_data | input | 8 | Write data; a 1 in bit 0 clears the change flag |
| reg_rd_data | output | 8 | Current status register value |
| pcm_in_req | input | N_PCM_IN (3) | PCM capture channel interrupt requests |
| mdm_out_req | input | N_MDM_OUT (2) | Modem transmit channel interrupt requests |
| mdm_in_req | input | N_MDM_IN (2) | Modem receive channel interrupt requests |
| frame_valid | input | 1 | Strobe marking a received frame's slot-12 word |
| slot12_data | input | SLOT_W (20) | Slot-12 word of the received frame |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A summary register with the wrong value shows up on `reg_rd_data` and on `irq_out` one cycle after the requests change. The bench therefore compares every bit on every cycle, so a stale or wrongly grouped summary is caught within one clock. A fault in the sticky flag shows up only after a particular sequence of events: it may be lost on a write of 0, survive a write of 1, or lose the race when set and clear arrive together. Directed sequences put each of these cases on the read bus within two cycles of the stimulus, and long random runs cover the interleavings between them.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;

    localparam int REG_W      = 8;
    localparam int SLOT_W_DEF = 20;

    // bit positions software decodes
    localparam int POS_GPI_CHG = 0;
    localparam int POS_MDM_IN  = 1;
    localparam int POS_MDM_OUT = 2;
    localparam int POS_PCM_IN  = 5;

    typedef struct packed {
        logic [1:0] spare_hi;   // 7:6
        logic       pcm_in;     // 5
        logic [1:0] spare_mid;  // 4:3
        logic       mdm_out;    // 2
        logic       mdm_in;     // 1
        logic       gpi_chg;    // 0
    } irq_status_t;

    typedef struct packed {
        logic pcm_in;
        logic mdm_out;
        logic mdm_in;
    } summary_t;

    function automatic irq_status_t build_status(summary_t s, logic gpi);
        irq_status_t r;
        r           = '0;
        r.pcm_in    = s.pcm_in;
        r.mdm_out   = s.mdm_out;
        r.mdm_in    = s.mdm_in;
        r.gpi_chg   = gpi;
        return r;
    endfunction

    function automatic logic any_active(irq_status_t r);
        return r.pcm_in | r.mdm_out | r.mdm_in | r.gpi_chg;
    endfunction

endpackage

// File: rtl/codec_irq_summary.sv
module codec_irq_summary #(
    parameter int N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    output logic             pending
);
    localparam int LVL = (N_REQ > 1) ? $clog2(N_REQ) : 1;
    localparam int PAD = 1 << LVL;

    logic [PAD-1:0] leaf;
    logic [2*PAD-2:0] tree;

    always_comb begin
        leaf = '0;
        leaf[N_REQ-1:0] = req;
    end

    // balanced OR tree: nodes [PAD-1 .. 2*PAD-2] are leaves, node 0 is root
    genvar gi;
    generate
        for (gi = 0; gi < PAD; gi++) begin : g_leaf
            assign tree[PAD-1+gi] = leaf[gi];
        end
        for (gi = 0; gi < PAD-1; gi++) begin : g_node
            assign tree[gi] = tree[2*gi+1] | tree[2*gi+2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= tree[0];
    end

    p_tracks_req_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pending == $past(|req)));

endmodule

// File: rtl/codec_irq_gpi_flag.sv
module codec_irq_gpi_flag #(
    parameter int SLOT_W  = 20,
    parameter int GPI_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [SLOT_W-1:0] slot_word,
    input  logic              clr_req,
    output logic              flag
);
    logic set_evt;
    assign set_evt = frame_valid & slot_word[GPI_BIT];

    logic unused_slot_rest;
    assign unused_slot_rest = ^slot_word;

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;   // set beats clear
        else if (clr_req) flag <= 1'b0;
    end

    p_set_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && slot_word[GPI_BIT]) |=> flag);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !(frame_valid && slot_word[GPI_BIT])) |=> !flag);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(frame_valid && slot_word[GPI_BIT])) |=> !flag);

endmodule

// File: rtl/codec_irq_status.sv
module codec_irq_status
    import codec_irq_pkg::*;
#(
    parameter int N_PCM_IN  = 3,
    parameter int N_MDM_OUT = 2,
    parameter int N_MDM_IN  = 2,
    parameter int SLOT_W    = SLOT_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [REG_W-1:0]     reg_wr_data,
    output logic [REG_W-1:0]     reg_rd_data,
    input  logic [N_PCM_IN-1:0]  pcm_in_req,
    input  logic [N_MDM_OUT-1:0] mdm_out_req,
    input  logic [N_MDM_IN-1:0]  mdm_in_req,
    input  logic                 frame_valid,
    input  logic [SLOT_W-1:0]    slot12_data,
    output logic                 irq_out
);
    summary_t    summ;
    logic        gpi_flag;
    logic        clr_gpi;
    irq_status_t status;

    codec_irq_summary #(.N_REQ(N_PCM_IN)) u_sum_pcm (
        .clk(clk), .rst(rst), .req(pcm_in_req), .pending(summ.pcm_in));
    codec_irq_summary #(.N_REQ(N_MDM_OUT)) u_sum_mout (
        .clk(clk), .rst(rst), .req(mdm_out_req), .pending(summ.mdm_out));
    codec_irq_summary #(.N_REQ(N_MDM_IN)) u_sum_min (
        .clk(clk), .rst(rst), .req(mdm_in_req), .pending(summ.mdm_in));

    // only bit 0 of a write has meaning; everything else is dropped here
    assign clr_gpi = reg_wr_en & reg_wr_data[POS_GPI_CHG];

    logic unused_wr_bits;
    assign unused_wr_bits = ^reg_wr_data;

    codec_irq_gpi_flag #(.SLOT_W(SLOT_W), .GPI_BIT(0)) u_gpi (
        .clk(clk), .rst(rst), .frame_valid(frame_valid),
        .slot_word(slot12_data), .clr_req(clr_gpi), .flag(gpi_flag));

    assign status      = build_status(summ, gpi_flag);
    assign reg_rd_data = status;
    assign irq_out     = any_active(status);

    p_spare_zero_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (reg_rd_data[7:6] == 2'b00 && reg_rd_data[4:3] == 2'b00));

    p_mout_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (reg_rd_data[POS_MDM_OUT] == $past(|mdm_out_req)));

    p_min_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (reg_rd_data[POS_MDM_IN] == $past(|mdm_in_req)));

    p_race_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_gpi && frame_valid && slot12_data[0]) |=> reg_rd_data[POS_GPI_CHG]);

    p_irq_r11: assert property (@(posedge clk) disable iff (rst)
        irq_out == (reg_rd_data[5] | reg_rd_data[2] | reg_rd_data[1] | reg_rd_data[0]));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (reg_rd_data == '0 && !irq_out));

endmodule

// File: tb/codec_irq_status_bench.sv
module codec_irq_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3, NO = 2, NI = 2, SW = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic we = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic [NP-1:0] pcm = '0;
    logic [NO-1:0] mo = '0;
    logic [NI-1:0] mi = '0;
    logic fv = 1'b0;
    logic [SW-1:0] slot = '0;
    logic irq;

    int checks = 0, failures = 0;
    bit done = 0;
    logic m_pcm, m_mo, m_mi, m_gpi;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_irq_status u_codec_irq_status (
        .clk(clk), .rst(rst), .reg_wr_en(we), .reg_wr_data(wd),
        .reg_rd_data(rd), .pcm_in_req(pcm), .mdm_out_req(mo),
        .mdm_in_req(mi), .frame_valid(fv), .slot12_data(slot),
        .irq_out(irq));

    function automatic logic [7:0] exp_reg(logic p, logic o, logic i, logic g);
        return {2'b00, p, 2'b00, o, i, g};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [7:0] e;
        e = exp_reg(m_pcm, m_mo, m_mi, m_gpi);
        chk("R2 pcm summary", {7'd0, rd[5]}, {7'd0, e[5]});
        chk("R3 mdm-out summary", {7'd0, rd[2]}, {7'd0, e[2]});
        chk("R4 mdm-in summary", {7'd0, rd[1]}, {7'd0, e[1]});
        chk("R5 spare bits", {4'd0, rd[7:6], rd[4:3]}, 8'd0);
        chk("R6/R7/R8/R9 gpi flag", {7'd0, rd[0]}, {7'd0, e[0]});
        chk("R11 irq", {7'd0, irq}, {7'd0, |e});
    endtask

    // drive at negedge, model update at posedge, check at next negedge
    task automatic step(logic [NP-1:0] p, logic [NO-1:0] o, logic [NI-1:0] i,
                        logic f, logic [SW-1:0] s, logic w, logic [7:0] d);
        pcm = p; mo = o; mi = i; fv = f; slot = s; we = w; wd = d;
        @(posedge clk);
        m_pcm = |p; m_mo = |o; m_mi = |i;
        if (f && s[0])      m_gpi = 1'b1;
        else if (w && d[0]) m_gpi = 1'b0;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        m_pcm = 0; m_mo = 0; m_mi = 0; m_gpi = 0;
        void'($urandom(32'h1234_5678));
        // R1: reset holds zero despite active inputs
        @(negedge clk);
        pcm = '1; mo = '1; mi = '1; fv = 1; slot = '1;
        repeat (3) @(negedge clk);
        chk("R1 reset reg", rd, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        rst = 0; pcm = '0; mo = '0; mi = '0; fv = 0; slot = '0;
        step('0, '0, '0, 0, '0, 0, 8'h00);
        // R6: frame with bit0 clear, others set -> no set
        step('0, '0, '0, 1, 20'hFFFFE, 0, 8'h00);
        // R6: bit0 set but frame_valid low -> no set
        step('0, '0, '0, 0, 20'h00001, 0, 8'h00);
        // R6: set
        step('0, '0, '0, 1, 20'h00001, 0, 8'h00);
        // R7: write 0 to bit 0 keeps flag
        step('0, '0, '0, 0, '0, 1, 8'hFE);
        step('0, '0, '0, 0, '0, 0, 8'h00);
        // R8: write 1 clears
        step('0, '0, '0, 0, '0, 1, 8'h01);
        chk("R8 cleared", {7'd0, rd[0]}, 8'h00);
        // R9: set and clear together -> set
        step('0, '0, '0, 1, 20'h00001, 1, 8'h01);
        chk("R9 set wins", {7'd0, rd[0]}, 8'h01);
        step('0, '0, '0, 0, '0, 1, 8'h01);
        // R5/R10: writes to spare and summary bits ignored
        step('0, '0, '0, 0, '0, 1, 8'hFE);
        chk("R10 summaries not written", rd, 8'h00);
        step(3'b100, 2'b01, 2'b10, 0, '0, 1, 8'h00);
        chk("R10 summaries kept", rd, 8'h26);
        // each group alone
        step(3'b010, '0, '0, 0, '0, 0, 8'h00);
        step('0, 2'b10, '0, 0, '0, 0, 8'h00);
        step('0, '0, 2'b01, 0, '0, 0, 8'h00);
        step('0, '0, '0, 0, '0, 0, 8'h00);
        chk("R11 irq idle", {7'd0, irq}, 8'h00);
        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [NP-1:0] p; logic [NO-1:0] o; logic [NI-1:0] i;
            logic f; logic [SW-1:0] s; logic w; logic [7:0] d;
            p = ($urandom % 3 == 0) ? NP'($urandom) : '0;
            o = ($urandom % 3 == 0) ? NO'($urandom) : '0;
            i = ($urandom % 3 == 0) ? NI'($urandom) : '0;
            f = ($urandom % 4 == 0);
            s = SW'($urandom);
            w = ($urandom % 3 == 0);
            d = 8'($urandom);
            step(p, o, i, f, s, w, d);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule